// File: doc/BRIEF.md
# Push-Pull Two-Wire Bus Master

This block is a master controller for a serial bus with one target and two wires, a clock line and a data line. Both lines are driven actively, with no pull-up, and the block turns the data line around whenever the target has to drive it. Start and stop conditions look like I2C: the data line falls while the clock is high to open a frame, and it rises while the clock is high to close one. No device address is sent. Each frame opens with one direction bit, followed by an 8-bit register address and its parity bit.

A host starts a transfer by raising `req_valid` while `busy` is low. A write sends 8 data bits and a parity bit, then releases the data line for one acknowledge slot. A read releases the data line for nine slots, in which the target returns 8 data bits and a parity bit. The master sends no acknowledge on a read and goes straight to the stop condition. When the stop condition has completed, `done` pulses for one cycle. At that point `rdata`, `par_err` and `nack` hold the results of the transfer.

The controller is a single state machine. Its states are IDLE, START, TX_LO, TX_HI, RX_LO, RX_HI, ACK_LO, ACK_HI, STOP_LO, STOP_HI and STOP_END. Apart from IDLE, each state lasts exactly one half-period of `DIV` system clocks. The transitions are:
- IDLE→START on an accepted request.
- START→TX_LO and TX_LO→TX_HI.
- TX_HI→TX_LO while bits remain to be sent.
- TX_HI→RX_LO after the last header bit of a read.
- TX_HI→ACK_LO after the data parity bit of a write.
- RX_LO→RX_HI.
- RX_HI→RX_LO while read bits remain.
- RX_HI→STOP_LO after the ninth read bit.
- ACK_LO→ACK_HI and ACK_HI→STOP_LO.
- STOP_LO→STOP_HI→STOP_END→IDLE.

Top module: `pp2w_master`

## Requirements
- R1: Out of reset and whenever idle, `busy`=0, `scl_o`=1, `sda_o`=1 and `sda_oe`=1. After reset, `rdata`=0, `par_err`=0 and `nack`=0.
- R2: A request is accepted on a clock edge where `req_valid`=1 and the block is idle. From the next cycle, `busy`=1 and SDA is driven low with SCL high for `DIV` cycles. This is the start condition.
- R3: Each bit slot is `DIV` cycles with SCL low, then `DIV` cycles with SCL high. A driven SDA value is set when the low half begins and holds through the high half.
- R4: The first bit after the start is the direction bit (1 = read, 0 = write). The 8 address bits follow, MSB first, then an even-parity bit equal to the XOR of the address bits.
- R5: A write then sends the 8 data bits MSB first and their even-parity bit. After that comes one acknowledge slot with `sda_oe`=0.
- R6: The acknowledge is sampled as SCL rises in the acknowledge slot. A low level gives `nack`=0 and a high level gives `nack`=1. The stop condition follows in both cases.
- R7: After the header, a read releases SDA (`sda_oe`=0) for 9 bit slots and samples `sda_i` as SCL rises in each. The first 8 samples form `rdata`, MSB first. No master acknowledge follows; the stop condition comes next.
- R8: On a read, `par_err`=1 exactly when the XOR of the 9 sampled bits is 1. A target that holds SDA high for all 9 slots therefore gives `par_err`=1 and `rdata`=8'hFF.
- R9: The stop sequence has three half-periods: SCL low with SDA driven low, SCL high with SDA low, then SDA high with SCL high. In the cycle after that, `busy`=0 and `done`=1 for exactly one cycle.
- R10: A `req_valid` raised while `busy`=1 is ignored. The bus sequence in progress and its results are unchanged.
- R11: Accepting a request clears `rdata`, `par_err` and `nack`. A write therefore ends with `rdata`=0 and `par_err`=0, and a read ends with `nack`=0.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| rdata | output | DATA_W | Data returned by the last read |
| par_err | output | 1 | Parity of the last read was wrong |
| nack | output | 1 | Target did not acknowledge the last write |
| scl_o | output | 1 | Clock line, always driven |
| sda_o | output | 1 | Data line value when driven |
| sda_oe | output | 1 | 1 = master drives SDA, 0 = target drives it |
| sda_i | input | 1 | Data line as seen at the pin |

## Verification
All pin outputs are registered from the next state. The first start-condition cycle therefore appears one clock after the accepting edge, and every later half-period boundary falls exactly `DIV` cycles after the one before it. A write spans 44 half-periods and a read spans 42. The bench builds that expected pin sequence per cycle in a queue and compares it at each falling clock edge. `done`, `busy`=0 and the result flags are due in the single cycle that follows the last stop half-period, 44·DIV+1 cycles after acceptance for a write and 42·DIV+1 for a read. The bench checks them at that cycle and checks one cycle later that `done` has dropped. The target model changes `sda_i` at the first falling clock edge after SCL falls with SDA released. Each value therefore stands for a whole low half before the master samples it.

// File: rtl/pp2w_pkg.sv
package pp2w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_TX_LO,
        ST_TX_HI,
        ST_RX_LO,
        ST_RX_HI,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_STOP_END
    } pp2w_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic oe;
    } pp2w_pins_t;

    // Line levels for each state; txb is the bit currently being sent.
    function automatic pp2w_pins_t pins_for(pp2w_state_e s, logic txb);
        pp2w_pins_t p;
        unique case (s)
            ST_IDLE:     p = '{scl: 1'b1, sda: 1'b1, oe: 1'b1};
            ST_START:    p = '{scl: 1'b1, sda: 1'b0, oe: 1'b1};
            ST_TX_LO:    p = '{scl: 1'b0, sda: txb,  oe: 1'b1};
            ST_TX_HI:    p = '{scl: 1'b1, sda: txb,  oe: 1'b1};
            ST_RX_LO:    p = '{scl: 1'b0, sda: 1'b1, oe: 1'b0};
            ST_RX_HI:    p = '{scl: 1'b1, sda: 1'b1, oe: 1'b0};
            ST_ACK_LO:   p = '{scl: 1'b0, sda: 1'b1, oe: 1'b0};
            ST_ACK_HI:   p = '{scl: 1'b1, sda: 1'b1, oe: 1'b0};
            ST_STOP_LO:  p = '{scl: 1'b0, sda: 1'b0, oe: 1'b1};
            ST_STOP_HI:  p = '{scl: 1'b1, sda: 1'b0, oe: 1'b1};
            ST_STOP_END: p = '{scl: 1'b1, sda: 1'b1, oe: 1'b1};
            default:     p = '{scl: 1'b1, sda: 1'b1, oe: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pp2w_slot_timer.sv
// Half-period timer: tick marks the last cycle of each DIV-cycle slot.
module pp2w_slot_timer #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/pp2w_frame_build.sv
// Builds the left-aligned outbound bit string and its length.
module pp2w_frame_build #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 5
) (
    input  logic                             rd,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [ADDR_W+DATA_W+2:0]         frame,
    output logic [LEN_W-1:0]                 nbits
);
    localparam int WR_BITS = ADDR_W + DATA_W + 3;
    localparam int RD_BITS = ADDR_W + 2;

    logic addr_par;
    logic data_par;

    assign addr_par = ^addr;
    assign data_par = ^wdata;

    always_comb begin
        if (rd) begin
            frame = {1'b1, addr, addr_par, {(DATA_W + 1){1'b0}}};
            nbits = LEN_W'(RD_BITS);
        end else begin
            frame = {1'b0, addr, addr_par, wdata, data_par};
            nbits = LEN_W'(WR_BITS);
        end
    end
endmodule

// File: rtl/pp2w_rx_capture.sv
// Collects the 9 inbound bits; flags odd overall parity.
module pp2w_rx_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data,
    output logic              perr
);
    logic [DATA_W:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (clr) begin
            sr <= '0;
        end else if (shift) begin
            sr <= {sr[DATA_W-1:0], bit_in};
        end
    end

    assign data = sr[DATA_W:1];
    assign perr = ^sr;
endmodule

// File: rtl/pp2w_master.sv
module pp2w_master
    import pp2w_pkg::*;
#(
    parameter int DIV    = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              par_err,
    output logic              nack,
    output logic              scl_o,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic              sda_i
);
    localparam int FW      = ADDR_W + DATA_W + 3;
    localparam int RX_BITS = DATA_W + 1;
    localparam int LEN_W   = $clog2(FW + 1);

    pp2w_state_e      state, state_nxt;
    logic [FW-1:0]    tx_sr, tx_nxt;
    logic [LEN_W-1:0] bit_left, left_nxt;
    logic             rd_q;
    logic             slot_tick;
    logic             accept;
    logic [FW-1:0]    frame_word;
    logic [LEN_W-1:0] frame_len;
    pp2w_pins_t       pins_nxt;

    assign accept = (state == ST_IDLE) && req_valid;

    pp2w_slot_timer #(.DIV(DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .run   (state != ST_IDLE),
        .tick  (slot_tick)
    );

    pp2w_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_frame (
        .rd    (req_rd),
        .addr  (req_addr),
        .wdata (req_wdata),
        .frame (frame_word),
        .nbits (frame_len)
    );

    pp2w_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .shift  ((state == ST_RX_LO) && slot_tick),
        .bit_in (sda_i),
        .data   (rdata),
        .perr   (par_err)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        tx_nxt    = tx_sr;
        left_nxt  = bit_left;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nxt = ST_START;
                    tx_nxt    = frame_word;
                    left_nxt  = frame_len;
                end
            end
            ST_START: begin
                if (slot_tick) state_nxt = ST_TX_LO;
            end
            ST_TX_LO: begin
                if (slot_tick) state_nxt = ST_TX_HI;
            end
            ST_TX_HI: begin
                if (slot_tick) begin
                    tx_nxt = tx_sr << 1;
                    if (bit_left == LEN_W'(1)) begin
                        if (rd_q) begin
                            state_nxt = ST_RX_LO;
                            left_nxt  = LEN_W'(RX_BITS);
                        end else begin
                            state_nxt = ST_ACK_LO;
                        end
                    end else begin
                        state_nxt = ST_TX_LO;
                        left_nxt  = bit_left - LEN_W'(1);
                    end
                end
            end
            ST_RX_LO: begin
                if (slot_tick) state_nxt = ST_RX_HI;
            end
            ST_RX_HI: begin
                if (slot_tick) begin
                    if (bit_left == LEN_W'(1)) begin
                        state_nxt = ST_STOP_LO;
                    end else begin
                        state_nxt = ST_RX_LO;
                        left_nxt  = bit_left - LEN_W'(1);
                    end
                end
            end
            ST_ACK_LO: begin
                if (slot_tick) state_nxt = ST_ACK_HI;
            end
            ST_ACK_HI: begin
                if (slot_tick) state_nxt = ST_STOP_LO;
            end
            ST_STOP_LO: begin
                if (slot_tick) state_nxt = ST_STOP_HI;
            end
            ST_STOP_HI: begin
                if (slot_tick) state_nxt = ST_STOP_END;
            end
            ST_STOP_END: begin
                if (slot_tick) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tx_sr    <= '0;
            bit_left <= '0;
            rd_q     <= 1'b0;
            nack     <= 1'b0;
        end else begin
            state    <= state_nxt;
            tx_sr    <= tx_nxt;
            bit_left <= left_nxt;
            if (accept) begin
                rd_q <= req_rd;
                nack <= 1'b0;
            end else if ((state == ST_ACK_LO) && slot_tick) begin
                nack <= sda_i;
            end
        end
    end

    // Registered line and handshake outputs
    assign pins_nxt = pins_for(state_nxt, tx_nxt[FW-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o  <= 1'b1;
            sda_o  <= 1'b1;
            sda_oe <= 1'b1;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            scl_o  <= pins_nxt.scl;
            sda_o  <= pins_nxt.sda;
            sda_oe <= pins_nxt.oe;
            busy   <= (state_nxt != ST_IDLE);
            done   <= (state == ST_STOP_END) && slot_tick;
        end
    end
endmodule

// File: rtl/pp2w_sva.sv
module pp2w_sva (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic scl_o,
    input logic sda_o,
    input logic sda_oe,
    input logic slot_tick
);
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o && sda_oe));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_start_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && sda_oe && $past(sda_oe) && $fell(sda_o)) |-> $rose(busy));

    p_scl_on_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(scl_o)) |-> $past(slot_tick));

    p_stop_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && sda_oe && $past(sda_oe) && $rose(sda_o)) |-> (busy && !done));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_o);
endmodule

bind pp2w_master pp2w_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .scl_o     (scl_o),
    .sda_o     (sda_o),
    .sda_oe    (sda_oe),
    .slot_tick (slot_tick)
);

// File: tb/sim_pp2w_master.sv
module sim_pp2w_master;
    localparam int DIV = 3;
    localparam int AW  = 8;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_rd = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done, par_err, nack, scl_o, sda_o, sda_oe;
    logic [DW-1:0] rdata;
    logic          sda_i = 1'b1;

    int n_vec = 0;
    int n_bad = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic       tgt_q[$];
    logic       prev_scl = 1'b1;

    always #10 clk = ~clk;

    pp2w_master #(.DIV(DIV), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .par_err(par_err), .nack(nack), .scl_o(scl_o),
        .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    // Target model: presents its next bit once SCL has fallen with SDA released
    always @(negedge clk) begin
        if (prev_scl && !scl_o && !sda_oe)
            sda_i <= (tgt_q.size() > 0) ? tgt_q.pop_front() : 1'b1;
        prev_scl <= scl_o;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic add_slot(input logic scl, input logic sda, input logic oe, input string tag);
        for (int k = 0; k < DIV; k++) begin
            exp_q.push_back({scl, sda, oe});
            tag_q.push_back(tag);
        end
    endtask

    task automatic add_bit(input logic b, input string tag);
        add_slot(1'b0, b, 1'b1, tag);
        add_slot(1'b1, b, 1'b1, tag);
    endtask

    task automatic add_rel(input string tag);
        add_slot(1'b0, 1'b1, 1'b0, tag);
        add_slot(1'b1, 1'b1, 1'b0, tag);
    endtask

    // One transfer, compared cycle by cycle; called at a falling edge
    task automatic run(input logic rd, input logic [7:0] addr, input logic [7:0] wd,
                       input logic [8:0] resp, input logic ackb, input bit hold);
        logic [2:0]    e;
        string         t;
        logic [DW-1:0] x_rdata;
        logic          x_perr, x_nack;
        bit            first;
        x_rdata = rd ? resp[8:1] : '0;
        x_perr  = rd ? ^resp : 1'b0;
        x_nack  = rd ? 1'b0 : ackb;
        if (rd) for (int i = 8; i >= 0; i--) tgt_q.push_back(resp[i]);
        else    tgt_q.push_back(ackb);

        add_slot(1'b1, 1'b0, 1'b1, "R2");
        add_bit(rd, "R4");
        for (int i = 7; i >= 0; i--) add_bit(addr[i], "R4");
        add_bit(^addr, "R4");
        if (!rd) begin
            for (int i = 7; i >= 0; i--) add_bit(wd[i], "R5");
            add_bit(^wd, "R5");
            add_rel("R6");
        end else begin
            for (int i = 0; i < 9; i++) add_rel("R7");
        end
        add_slot(1'b0, 1'b0, 1'b1, "R9");
        add_slot(1'b1, 1'b0, 1'b1, "R9");
        add_slot(1'b1, 1'b1, 1'b1, "R9");

        req_valid = 1'b1; req_rd = rd; req_addr = addr; req_wdata = wd;
        first = 1'b1;
        while (exp_q.size() > 0) begin
            @(negedge clk);
            if (first) begin
                first = 1'b0;
                if (hold) begin
                    req_rd = ~rd; req_addr = ~addr; req_wdata = ~wd;   // R10 stimulus
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (exp_q.size() < DIV) req_valid = 1'b0;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (hold) t = {t, "/R10"};
            chk(scl_o == e[2], t, "scl_o", 32'(scl_o), 32'(e[2]));
            chk(sda_oe == e[0], {t, "/R12"}, "sda_oe", 32'(sda_oe), 32'(e[0]));
            if (e[0]) chk(sda_o == e[1], t, "sda_o", 32'(sda_o), 32'(e[1]));
            chk(busy == 1'b1, t, "busy", 32'(busy), 32'd1);
            chk(done == 1'b0, t, "done", 32'(done), 32'd0);
        end
        @(negedge clk);
        chk(done == 1'b1, "R9", "done pulse", 32'(done), 32'd1);
        chk(busy == 1'b0, "R9", "busy at end", 32'(busy), 32'd0);
        chk({scl_o, sda_o, sda_oe} == 3'b111, "R1", "idle lines", 32'({scl_o, sda_o, sda_oe}), 32'h7);
        chk(rdata == x_rdata, rd ? "R7" : "R11", "rdata", 32'(rdata), 32'(x_rdata));
        chk(par_err == x_perr, rd ? "R8" : "R11", "par_err", 32'(par_err), 32'(x_perr));
        chk(nack == x_nack, rd ? "R11" : "R6", "nack", 32'(nack), 32'(x_nack));
        @(negedge clk);
        chk(done == 1'b0, "R9", "done after pulse", 32'(done), 32'd0);
        chk(busy == 1'b0, "R10", "no late accept", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: got no end of run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({scl_o, sda_o, sda_oe, busy, done} == 5'b11100, "R1", "lines in reset",
            32'({scl_o, sda_o, sda_oe, busy, done}), 32'h1C);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({scl_o, sda_o, sda_oe, busy, done} == 5'b11100, "R1", "lines idle",
            32'({scl_o, sda_o, sda_oe, busy, done}), 32'h1C);
        chk({rdata, par_err, nack} == '0, "R1", "results after reset",
            32'({rdata, par_err, nack}), 32'd0);

        run(1'b0, 8'h5A, 8'h3C, 9'h000, 1'b0, 1'b0);        // write, acked
        run(1'b0, 8'h80, 8'hFF, 9'h000, 1'b1, 1'b0);        // write, not acked
        run(1'b1, 8'h13, 8'h00, {8'hA5, 1'b0}, 1'b0, 1'b0); // read, good parity, nack cleared
        run(1'b1, 8'h42, 8'h00, {8'h01, 1'b0}, 1'b0, 1'b0); // read, bad parity
        run(1'b0, 8'h7E, 8'h81, 9'h000, 1'b0, 1'b1);        // write, request held while busy
        run(1'b1, 8'hC3, 8'h00, 9'h1FF, 1'b0, 1'b0);        // target error: all ones
        run(1'b1, 8'h00, 8'h00, 9'h000, 1'b0, 1'b0);        // read all zeros

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule